// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of eight ownership latches that two independent ports, called left and right, use to reserve shared resources. Each port has its own semaphore select, write strobe, output enable, a 3-bit latch index and a single write data bit. A port asks for a latch by writing 0 to it and gives the latch back by writing 1. It then confirms ownership by reading the latch: a read returns all zeros to the holder and all ones to anyone else.

A request that loses stays queued in the latch. When the holder later writes 1, the queued port becomes the holder with no further action, and its next read returns zero. A queued port can withdraw its request by writing 1. Each latch is a five-state machine with these states: FREE, HELD_L, HELD_R, HELD_L_WAIT_R (left holds, right queued) and HELD_R_WAIT_L (right holds, left queued). The transitions are grant (FREE to HELD_x), queue (HELD_x to HELD_x_WAIT_y), cancel (HELD_x_WAIT_y to HELD_x), handover (HELD_x_WAIT_y to HELD_y, or HELD_x to HELD_y when the other port requests in the same cycle as the release) and release (HELD_x to FREE). Each port also has a two-state access machine. PORT_READY moves to PORT_SETTLE on any write. PORT_SETTLE moves back to PORT_READY on the first cycle with no write in which select or output enable is low. Reads are taken only in PORT_READY.

Top module: `dual_port_semaphore`

## Requirements
- R1: The eight latches are independent. An access changes only the latch named by its 3-bit index, and no latch is ever held by both ports at once.
- R2: A port that writes data bit 0 = 0 to a FREE latch becomes its holder.
- R3: A read returns 0 in bit 0 to the port holding the addressed latch and 1 to a port that does not hold it. The value appears on the read data output one clock after the read cycle and stays there until the next accepted read.
- R4: A write of 1 by the holder, when the other port has nothing queued and does not request in the same cycle, returns the latch to FREE.
- R5: A write of 0 to a latch held by the other port queues the request, and the requester keeps reading 1. When the holder writes 1, the queued port becomes holder and reads 0.
- R6: A write of 1 by a queued non-holder withdraws its request. A later release by the holder then leaves the latch FREE.
- R7: When both ports write 0 to the same FREE latch in the same cycle, left becomes holder and right is queued.
- R8: After reset every latch is FREE with nothing queued, and both read data outputs are all ones.
- R9: After a port writes, its reads are ignored and its read data holds its value. This lasts until the port has spent one cycle with no write and with select or output enable low.
- R10: Every bit of a read data output carries the same value as bit 0.
- R11: A cycle with select low performs no access, whatever the write strobe, output enable, index and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_idx | input | 3 | Left latch index |
| l_wbit | input | 1 | Left write data bit 0 (0 = request, 1 = release) |
| l_rdata | output | 16 | Left read data |
| r_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_idx | input | 3 | Right latch index |
| r_wbit | input | 1 | Right write data bit 0 (0 = request, 1 = release) |
| r_rdata | output | 16 | Right read data |

## Verification
The assertions check on every cycle that no latch has two holders, that read data is uniformly all zeros or all ones, that read data stays frozen for two cycles after a write, that a request to a free latch and a release by the holder take effect on the next cycle, and that idle cycles change no ownership. Queuing, handover to a waiting port, cancelling a queued request and the left-wins tie can only be shown through bench scenarios. In those scenarios a reference model follows each latch over several cycles and compares both ports' read data after every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [2:0] {
        SEM_FREE,
        SEM_HELD_L,
        SEM_HELD_R,
        SEM_HELD_L_WAIT_R,
        SEM_HELD_R_WAIT_L
    } sem_state_e;

    typedef enum logic {
        PORT_READY,
        PORT_SETTLE
    } port_state_e;

endpackage

// File: rtl/sem_latch_fsm.sv
module sem_latch_fsm
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own
);

    sem_state_e state_q;
    sem_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (l_req)      state_d = r_req ? SEM_HELD_L_WAIT_R : SEM_HELD_L;
                else if (r_req) state_d = SEM_HELD_R;
            end
            SEM_HELD_L: begin
                if (l_rel)      state_d = r_req ? SEM_HELD_R : SEM_FREE;
                else if (r_req) state_d = SEM_HELD_L_WAIT_R;
            end
            SEM_HELD_R: begin
                if (r_rel)      state_d = l_req ? SEM_HELD_L : SEM_FREE;
                else if (l_req) state_d = SEM_HELD_R_WAIT_L;
            end
            SEM_HELD_L_WAIT_R: begin
                if (l_rel)      state_d = r_rel ? SEM_FREE : SEM_HELD_R;
                else if (r_rel) state_d = SEM_HELD_L;
            end
            SEM_HELD_R_WAIT_L: begin
                if (r_rel)      state_d = l_rel ? SEM_FREE : SEM_HELD_L;
                else if (l_rel) state_d = SEM_HELD_R;
            end
            default:            state_d = SEM_FREE;
        endcase
    end

    always_comb begin
        l_own = (state_q == SEM_HELD_L) || (state_q == SEM_HELD_L_WAIT_R);
        r_own = (state_q == SEM_HELD_R) || (state_q == SEM_HELD_R_WAIT_L);
    end

endmodule

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic               oe,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wbit,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec,
    output logic [DATA_W-1:0]  rdata
);

    port_state_e state_q;
    port_state_e state_d;
    logic        do_write;
    logic        do_read;
    logic        read_ok;

    assign do_write = sel && wr;
    assign do_read  = sel && oe && !wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_READY: begin
                if (do_write) state_d = PORT_SETTLE;
            end
            PORT_SETTLE: begin
                if (do_write)            state_d = PORT_SETTLE;
                else if (!(sel && oe))   state_d = PORT_READY;
            end
            default: state_d = PORT_READY;
        endcase
    end

    always_comb begin
        req_vec = '0;
        rel_vec = '0;
        read_ok = do_read && (state_q == PORT_READY);
        for (int k = 0; k < NUM_SEM; k++) begin
            if (do_write && (idx == IDX_W'(k))) begin
                req_vec[k] = !wbit;
                rel_vec[k] = wbit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata <= '1;
        else if (read_ok) rdata <= {DATA_W{~own_vec[idx]}};
    end

endmodule

// File: rtl/dual_port_semaphore.sv
module dual_port_semaphore
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_SEM-1:0] l_req;
    logic [NUM_SEM-1:0] l_rel;
    logic [NUM_SEM-1:0] r_req;
    logic [NUM_SEM-1:0] r_rel;
    logic [NUM_SEM-1:0] l_own;
    logic [NUM_SEM-1:0] r_own;

    sem_port_ctrl #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_left (
        .clk(clk), .rst_n(rst_n), .sel(l_sel), .wr(l_wr), .oe(l_oe),
        .idx(l_idx), .wbit(l_wbit), .own_vec(l_own),
        .req_vec(l_req), .rel_vec(l_rel), .rdata(l_rdata)
    );

    sem_port_ctrl #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_right (
        .clk(clk), .rst_n(rst_n), .sel(r_sel), .wr(r_wr), .oe(r_oe),
        .idx(r_idx), .wbit(r_wbit), .own_vec(r_own),
        .req_vec(r_req), .rel_vec(r_rel), .rdata(r_rdata)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_latch
        sem_latch_fsm u_latch (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .l_own(l_own[g]), .r_own(r_own[g])
        );
    end

endmodule

// File: rtl/sem_bank_checker.sv
module sem_bank_checker #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel,
    input logic               l_wr,
    input logic [IDX_W-1:0]   l_idx,
    input logic               l_wbit,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel,
    input logic               r_wr,
    input logic [IDX_W-1:0]   r_idx,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] l_own,
    input logic [NUM_SEM-1:0] r_own
);

    assert_single_holder_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0);

    assert_uniform_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0) || (l_rdata == '1));

    assert_uniform_right_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rdata == '0) || (r_rdata == '1));

    assert_left_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_wr) |=> $stable(l_rdata) ##1 $stable(l_rdata));

    assert_right_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && r_wr) |=> $stable(r_rdata) ##1 $stable(r_rdata));

    assert_left_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_wr && !l_wbit && !l_own[l_idx] && !r_own[l_idx])
            |=> l_own[$past(l_idx)]);

    assert_left_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_wr && l_wbit && l_own[l_idx]) |=> !l_own[$past(l_idx)]);

    assert_idle_keeps_owners_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sel && !r_sel) |=> ($stable(l_own) && $stable(r_own)));

endmodule

bind dual_port_semaphore sem_bank_checker #(
    .NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_sem_bank_checker (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_idx(r_idx), .r_rdata(r_rdata),
    .l_own(l_own), .r_own(r_own)
);

// File: tb/test_dual_port_semaphore.sv
module test_dual_port_semaphore;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_sel = 0, l_wr = 0, l_oe = 0, l_wbit = 0;
    logic [2:0]  l_idx = '0;
    logic        r_sel = 0, r_wr = 0, r_oe = 0, r_wbit = 0;
    logic [2:0]  r_idx = '0;
    logic [15:0] l_rdata, r_rdata;

    int    checks = 0;
    int    failures = 0;
    string tag = "R8";

    // reference model: 0 free, 1 left holds, 2 right holds,
    // 3 left holds with right queued, 4 right holds with left queued
    int          st [8];
    bit          lrec, rrec;
    logic [15:0] exp_l, exp_r;

    always #5 clk = ~clk;

    dual_port_semaphore i_dual_port_semaphore (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_idx(l_idx), .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_idx(r_idx), .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    function automatic bit owns_l(int s);
        return (s == 1) || (s == 3);
    endfunction

    function automatic bit owns_r(int s);
        return (s == 2) || (s == 4);
    endfunction

    function automatic int next_st(int s, bit lq, bit lr, bit rq, bit rr);
        case (s)
            0: return lq ? (rq ? 3 : 1) : (rq ? 2 : 0);
            1: return lr ? (rq ? 2 : 0) : (rq ? 3 : 1);
            2: return rr ? (lq ? 1 : 0) : (lq ? 4 : 2);
            3: return lr ? (rr ? 0 : 2) : (rr ? 1 : 3);
            4: return rr ? (lr ? 0 : 1) : (lr ? 2 : 4);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic step(input logic ls, input logic lw, input logic lo, input logic [2:0] li,
                        input logic ld, input logic rs, input logic rw, input logic ro,
                        input logic [2:0] ri, input logic rd);
        @(negedge clk);
        l_sel = ls; l_wr = lw; l_oe = lo; l_idx = li; l_wbit = ld;
        r_sel = rs; r_wr = rw; r_oe = ro; r_idx = ri; r_wbit = rd;
        @(posedge clk);
        #1;
        if (ls && lo && !lw && !lrec) exp_l = owns_l(st[li]) ? 16'h0000 : 16'hFFFF;
        if (rs && ro && !rw && !rrec) exp_r = owns_r(st[ri]) ? 16'h0000 : 16'hFFFF;
        if (ls && lw) lrec = 1; else if (!(ls && lo)) lrec = 0;
        if (rs && rw) rrec = 1; else if (!(rs && ro)) rrec = 0;
        for (int k = 0; k < 8; k++)
            st[k] = next_st(st[k],
                            ls && lw && !ld && (li == 3'(k)), ls && lw && ld && (li == 3'(k)),
                            rs && rw && !rd && (ri == 3'(k)), rs && rw && rd && (ri == 3'(k)));
        chk(tag, l_rdata, exp_l);
        chk(tag, r_rdata, exp_r);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic lwr(input logic [2:0] i, input logic b);
        step(1, 1, 0, i, b, 0, 0, 0, 0, 0); idle();
    endtask
    task automatic rwr(input logic [2:0] i, input logic b);
        step(0, 0, 0, 0, 0, 1, 1, 0, i, b); idle();
    endtask
    task automatic lrd(input logic [2:0] i);
        step(1, 0, 1, i, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rrd(input logic [2:0] i);
        step(0, 0, 0, 0, 0, 1, 0, 1, i, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) st[k] = 0;
        lrec = 0; rrec = 0; exp_l = '1; exp_r = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state, nothing held
        chk("R8", l_rdata, 16'hFFFF);
        chk("R8", r_rdata, 16'hFFFF);
        tag = "R8"; lrd(5); chk("R8", l_rdata, 16'hFFFF);

        // R2 / R3 / R10: request then verify
        tag = "R2"; lwr(2, 0); lrd(2); chk("R2", l_rdata, 16'h0000);
        tag = "R3"; rrd(2); chk("R3", r_rdata, 16'hFFFF);

        // R5: queued request, handed over on release
        tag = "R5"; rwr(2, 0); rrd(2); chk("R5", r_rdata, 16'hFFFF);
        lwr(2, 1); rrd(2); chk("R5", r_rdata, 16'h0000);
        lrd(2); chk("R5", l_rdata, 16'hFFFF);

        // R6 / R4: cancel a queued request, then release leaves free
        tag = "R6"; lwr(2, 0); lwr(2, 1);
        tag = "R4"; rwr(2, 1); lrd(2); rrd(2);
        chk("R6", l_rdata, 16'hFFFF); chk("R4", r_rdata, 16'hFFFF);
        lwr(2, 0); lrd(2); chk("R4", l_rdata, 16'h0000); lwr(2, 1);

        // R7: simultaneous request, left wins, right queued
        tag = "R7"; step(1, 1, 0, 6, 0, 1, 1, 0, 6, 0); idle();
        step(1, 0, 1, 6, 0, 1, 0, 1, 6, 0);
        chk("R7", l_rdata, 16'h0000); chk("R7", r_rdata, 16'hFFFF);
        lwr(6, 1); rrd(6); chk("R7", r_rdata, 16'h0000); rwr(6, 1);

        // R1: independent latches
        tag = "R1"; lwr(3, 0); rwr(4, 0); lrd(4); chk("R1", l_rdata, 16'hFFFF);
        lrd(3); chk("R1", l_rdata, 16'h0000); rrd(3); chk("R1", r_rdata, 16'hFFFF);
        lwr(3, 1); rwr(4, 1);

        // R9: read right after a write is ignored until a gap
        tag = "R9"; lrd(0); held = l_rdata;
        step(1, 1, 1, 7, 0, 0, 0, 0, 0, 0);
        lrd(7); lrd(7); chk("R9", l_rdata, held);
        idle(); lrd(7); chk("R9", l_rdata, 16'h0000);
        lwr(7, 1);

        // R11: strobes without select do nothing
        tag = "R11"; step(0, 1, 1, 0, 0, 0, 1, 1, 0, 0); idle();
        lrd(0); rrd(0); chk("R11", l_rdata, 16'hFFFF); chk("R11", r_rdata, 16'hFFFF);
        lwr(1, 0); lrd(1); step(0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R11", l_rdata, 16'h0000); lwr(1, 1);

        // R10 with mixed random traffic against the model
        tag = "R10";
        for (int n = 0; n < 4000; n++) begin
            step(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom % 4), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom % 4), 1'($urandom));
        end
        summary();
    end

endmodule